// File: doc/BRIEF.md
# Privileged Stack Pointer Fetch Unit

This unit looks up the stack segment selector and the stack pointer that a task-state area holds for an inner privilege level (0, 1 or 2). It is started by a one-cycle request that carries the target level and the cached task-register descriptor: selector, base address, limit, type and a valid flag. It takes a snapshot of these values and picks the 16-bit or the 32-bit area layout from the type. It computes where the two fields sit and checks the extent of the access against the limit. It then fetches the pointer and the selector through a simple request/acknowledge memory port.

When the access would pass the limit, the unit reports a task-state fault with an error code built from the task-register selector. In that case it makes no memory access. A descriptor cache that is not valid, or a type that names neither layout, gives an unrecoverable-error flag and also makes no access. Each accepted request ends with exactly one `done_o` pulse. The results stay on the outputs until the next completion. The logic that consumes the result is outside this block.

Top module: `priv_stack_fetch`

## Requirements
- R1: After reset, `done_o`, `mem_req_o`, `fault_o` and `fatal_o` are all 0.
- R2: For type 9 or 11 (32-bit layout), the first read is 32-bit (`mem_wide_o`=1) at base + 8*level + 4 and `sp_o` takes all 32 bits of the returned data. The second read is 16-bit (`mem_wide_o`=0) at base + 8*level + 8 and `ss_o` takes data bits [15:0].
- R3: For type 1 or 3 (16-bit layout), the first read is 16-bit at base + 4*level + 2 and `sp_o` is data bits [15:0] zero-extended to 32 bits. The second read is 16-bit at base + 4*level + 4 and `ss_o` takes data bits [15:0].
- R4: In the 32-bit layout, a fault is raised exactly when 8*level + 4 + 7 is greater than the limit. A limit equal to that sum passes.
- R5: In the 16-bit layout, a fault is raised exactly when 4*level + 2 + 3 is greater than the limit. A limit equal to that sum passes.
- R6: On a fault, `done_o` pulses with `fault_o`=1, `fatal_o`=0 and `err_code_o` = selector AND 0xFFFC, and no memory read is issued for that request.
- R7: A descriptor with the valid flag at 0, or with any type other than 1, 3, 9 or 11, ends with `done_o`, `fatal_o`=1, `fault_o`=0 and no memory read.
- R8: Each accepted request gives exactly one one-cycle `done_o` pulse. A request raised while the unit is busy is ignored, which means it changes neither the addresses read nor the results.
- R9: Once `mem_req_o` is raised, it stays high with `mem_addr_o` and `mem_wide_o` unchanged until the cycle in which `mem_ack_i` is seen.
- R10: A successful fetch ends with `fault_o`=0, `fatal_o`=0 and `err_code_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start pulse, accepted only when idle |
| pl_i | input | 2 | Target privilege level, 0 to 2 |
| tr_sel_i | input | 16 | Task-register selector |
| tr_base_i | input | 32 | Task-state area base address |
| tr_limit_i | input | 32 | Task-state area limit (byte-granular) |
| tr_type_i | input | 4 | Descriptor type: 1/3 selects the 16-bit layout, 9/11 the 32-bit layout |
| tr_valid_i | input | 1 | Descriptor cache valid |
| mem_req_o | output | 1 | Memory read request, held until acknowledged |
| mem_addr_o | output | 32 | Read address |
| mem_wide_o | output | 1 | 1 = 32-bit read, 0 = 16-bit read |
| mem_ack_i | input | 1 | Read acknowledge, with data in the same cycle |
| mem_rdata_i | input | 32 | Read data; a 16-bit read uses bits [15:0] |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Limit violation on the last request |
| fatal_o | output | 1 | Unrecoverable descriptor error on the last request |
| err_code_o | output | 16 | Fault error code |
| ss_o | output | 16 | Fetched stack selector |
| sp_o | output | 32 | Fetched stack pointer |

## Verification
The hardest cases to reach from the ports are a second request that arrives during a fetch in flight and the exact limit boundary for each layout. The stimulus reaches the first by raising a request with a different level in the cycle after acceptance. It then checks that the reads still follow the first level and that only one `done_o` pulse appears. For the second, directed requests set the limit to the last passing value and to one below it for level 2 in both layouts. Random requests with small limits and random acknowledge delays cover the space between these cases.

// File: rtl/priv_stack_pkg.sv
package priv_stack_pkg;
  typedef enum logic [1:0] {FMT_BAD, FMT_16, FMT_32} tss_fmt_e;
  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_RD_SP, ST_RD_SS} fetch_st_e;
  localparam logic [3:0] TYPE_16_AVAIL = 4'd1;
  localparam logic [3:0] TYPE_16_BUSY  = 4'd3;
  localparam logic [3:0] TYPE_32_AVAIL = 4'd9;
  localparam logic [3:0] TYPE_32_BUSY  = 4'd11;
endpackage

// File: rtl/psf_offset_calc.sv
module psf_offset_calc
  import priv_stack_pkg::*;
#(
  parameter int AW = 32,
  parameter int TW = 4
) (
  input  logic [1:0]    pl_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] limit_i,
  input  logic [TW-1:0] type_i,
  input  logic          valid_i,
  output tss_fmt_e      fmt_o,
  output logic          lim_fault_o,
  output logic [AW-1:0] sp_addr_o,
  output logic [AW-1:0] ss_addr_o
);
  logic [AW-1:0] off32, off16, off, last_byte, ss_step;

  always_comb begin
    if (!valid_i) fmt_o = FMT_BAD;
    else begin
      case (type_i)
        TW'(TYPE_32_AVAIL), TW'(TYPE_32_BUSY): fmt_o = FMT_32;
        TW'(TYPE_16_AVAIL), TW'(TYPE_16_BUSY): fmt_o = FMT_16;
        default:                               fmt_o = FMT_BAD;
      endcase
    end
  end

  assign off32 = {{(AW-5){1'b0}}, pl_i, 3'b100};
  assign off16 = {{(AW-4){1'b0}}, pl_i, 2'b10};

  always_comb begin
    if (fmt_o == FMT_32) begin
      off       = off32;
      last_byte = off32 + AW'(7);
      ss_step   = AW'(4);
    end else begin
      off       = off16;
      last_byte = off16 + AW'(3);
      ss_step   = AW'(2);
    end
  end

  assign lim_fault_o = last_byte > limit_i;
  assign sp_addr_o   = base_i + off;
  assign ss_addr_o   = base_i + off + ss_step;
endmodule

// File: rtl/psf_ctrl.sv
module psf_ctrl
  import priv_stack_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int TW = 4,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [1:0]    pl_i,
  input  logic [SW-1:0] sel_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] limit_i,
  input  logic [TW-1:0] type_i,
  input  logic          valid_i,
  // snapshot towards the offset calculator
  output logic [1:0]    pl_q_o,
  output logic [AW-1:0] base_q_o,
  output logic [AW-1:0] limit_q_o,
  output logic [TW-1:0] type_q_o,
  output logic          valid_q_o,
  input  tss_fmt_e      fmt_i,
  input  logic          lim_fault_i,
  input  logic [AW-1:0] sp_addr_i,
  input  logic [AW-1:0] ss_addr_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_wide_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          fault_o,
  output logic          fatal_o,
  output logic [SW-1:0] err_code_o,
  output logic [SW-1:0] ss_o,
  output logic [DW-1:0] sp_o
);
  localparam logic [SW-1:0] ERR_MASK = ~SW'(3);

  fetch_st_e     st_q;
  logic [SW-1:0] sel_q;

  assign mem_req_o  = (st_q == ST_RD_SP) || (st_q == ST_RD_SS);
  assign mem_addr_o = (st_q == ST_RD_SS) ? ss_addr_i : sp_addr_i;
  assign mem_wide_o = (st_q == ST_RD_SP) && (fmt_i == FMT_32);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      sel_q      <= '0;
      pl_q_o     <= '0;
      base_q_o   <= '0;
      limit_q_o  <= '0;
      type_q_o   <= '0;
      valid_q_o  <= 1'b0;
      done_o     <= 1'b0;
      fault_o    <= 1'b0;
      fatal_o    <= 1'b0;
      err_code_o <= '0;
      ss_o       <= '0;
      sp_o       <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          sel_q     <= sel_i;
          pl_q_o    <= pl_i;
          base_q_o  <= base_i;
          limit_q_o <= limit_i;
          type_q_o  <= type_i;
          valid_q_o <= valid_i;
          st_q      <= ST_CHECK;
        end
        ST_CHECK: begin
          if (fmt_i == FMT_BAD) begin
            fatal_o    <= 1'b1;
            fault_o    <= 1'b0;
            err_code_o <= '0;
            done_o     <= 1'b1;
            st_q       <= ST_IDLE;
          end else if (lim_fault_i) begin
            fault_o    <= 1'b1;
            fatal_o    <= 1'b0;
            err_code_o <= sel_q & ERR_MASK;
            done_o     <= 1'b1;
            st_q       <= ST_IDLE;
          end else begin
            st_q <= ST_RD_SP;
          end
        end
        ST_RD_SP: if (mem_ack_i) begin
          sp_o <= (fmt_i == FMT_32) ? mem_rdata_i : {{(DW-16){1'b0}}, mem_rdata_i[15:0]};
          st_q <= ST_RD_SS;
        end
        ST_RD_SS: if (mem_ack_i) begin
          ss_o       <= mem_rdata_i[SW-1:0];
          fault_o    <= 1'b0;
          fatal_o    <= 1'b0;
          err_code_o <= '0;
          done_o     <= 1'b1;
          st_q       <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/priv_stack_fetch.sv
module priv_stack_fetch
  import priv_stack_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int TW = 4,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [1:0]    pl_i,
  input  logic [SW-1:0] tr_sel_i,
  input  logic [AW-1:0] tr_base_i,
  input  logic [AW-1:0] tr_limit_i,
  input  logic [TW-1:0] tr_type_i,
  input  logic          tr_valid_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_wide_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          fault_o,
  output logic          fatal_o,
  output logic [SW-1:0] err_code_o,
  output logic [SW-1:0] ss_o,
  output logic [DW-1:0] sp_o
);
  logic [1:0]    pl_q;
  logic [AW-1:0] base_q, limit_q, sp_addr, ss_addr;
  logic [TW-1:0] type_q;
  logic          valid_q, lim_fault;
  tss_fmt_e      fmt;

  psf_offset_calc #(.AW(AW), .TW(TW)) i_calc (
    .pl_i       (pl_q),
    .base_i     (base_q),
    .limit_i    (limit_q),
    .type_i     (type_q),
    .valid_i    (valid_q),
    .fmt_o      (fmt),
    .lim_fault_o(lim_fault),
    .sp_addr_o  (sp_addr),
    .ss_addr_o  (ss_addr)
  );

  psf_ctrl #(.AW(AW), .SW(SW), .TW(TW), .DW(DW)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .pl_i       (pl_i),
    .sel_i      (tr_sel_i),
    .base_i     (tr_base_i),
    .limit_i    (tr_limit_i),
    .type_i     (tr_type_i),
    .valid_i    (tr_valid_i),
    .pl_q_o     (pl_q),
    .base_q_o   (base_q),
    .limit_q_o  (limit_q),
    .type_q_o   (type_q),
    .valid_q_o  (valid_q),
    .fmt_i      (fmt),
    .lim_fault_i(lim_fault),
    .sp_addr_i  (sp_addr),
    .ss_addr_i  (ss_addr),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .mem_wide_o (mem_wide_o),
    .mem_ack_i  (mem_ack_i),
    .mem_rdata_i(mem_rdata_i),
    .done_o     (done_o),
    .fault_o    (fault_o),
    .fatal_o    (fatal_o),
    .err_code_o (err_code_o),
    .ss_o       (ss_o),
    .sp_o       (sp_o)
  );
endmodule

// File: rtl/priv_stack_fetch_chk.sv
module priv_stack_fetch_chk #(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_wide_o,
  input logic          mem_ack_i,
  input logic          done_o,
  input logic          fault_o,
  input logic          fatal_o,
  input logic [SW-1:0] err_code_o
);
  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wide_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  fault_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (fault_o || fatal_o) |-> !$past(mem_req_o));
  // R6
  err_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> err_code_o[1:0] == 2'b00);
  // R7
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(fault_o && fatal_o));
  // R10
  ok_err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o |-> err_code_o == '0);
endmodule

bind priv_stack_fetch priv_stack_fetch_chk #(.AW(AW), .SW(SW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mem_req_o (mem_req_o),
  .mem_addr_o(mem_addr_o),
  .mem_wide_o(mem_wide_o),
  .mem_ack_i (mem_ack_i),
  .done_o    (done_o),
  .fault_o   (fault_o),
  .fatal_o   (fatal_o),
  .err_code_o(err_code_o)
);

// File: tb/test_priv_stack_fetch.sv
module test_priv_stack_fetch;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  pl_i = '0;
  logic [15:0] tr_sel_i = '0;
  logic [31:0] tr_base_i = '0, tr_limit_i = '0;
  logic [3:0]  tr_type_i = '0;
  logic        tr_valid_i = 1'b0;
  logic        mem_req_o, mem_wide_o, mem_ack_i = 1'b0;
  logic [31:0] mem_addr_o, mem_rdata_i = '0;
  logic        done_o, fault_o, fatal_o;
  logic [15:0] err_code_o, ss_o;
  logic [31:0] sp_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk_i = ~clk_i;

  priv_stack_fetch i_priv_stack_fetch (.*);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return {~a[15:0], a[15:0] ^ 16'h3C5A};
  endfunction

  // run one request; extra=1 raises a second request while busy
  task automatic run(input logic [1:0] pl, input logic [15:0] sel, input logic [31:0] base,
                     input logic [31:0] lim, input logic [3:0] typ, input bit vld, input bit extra);
    bit          is32, is16, bad, flt;
    logic [31:0] off, a_sp, a_ss, e_sp;
    logic [31:0] r_addr [2];
    bit          r_wide [2];
    int          nrd = 0, ndone = 0, wcnt = 0, dly = 0, it = 0, after = -1;
    logic [31:0] g_sp = '0;
    logic [15:0] g_ss = '0, g_err = '0;
    bit          g_fault = 0, g_fatal = 0;
    is32 = vld && (typ == 4'd9 || typ == 4'd11);
    is16 = vld && (typ == 4'd1 || typ == 4'd3);
    bad  = !(is32 || is16);
    off  = is32 ? 32'(pl) * 8 + 4 : 32'(pl) * 4 + 2;
    flt  = !bad && ((off + (is32 ? 32'd7 : 32'd3)) > lim);
    a_sp = base + off;
    a_ss = a_sp + (is32 ? 32'd4 : 32'd2);
    e_sp = is32 ? mem_val(a_sp) : {16'h0, mem_val(a_sp)[15:0]};
    r_addr[0] = '0; r_addr[1] = '0; r_wide[0] = 0; r_wide[1] = 0;
    @(negedge clk_i);
    pl_i = pl; tr_sel_i = sel; tr_base_i = base; tr_limit_i = lim;
    tr_type_i = typ; tr_valid_i = vld; req_i = 1'b1;
    while (it < 60 && after != 0) begin
      @(negedge clk_i);
      it++;
      req_i = 1'b0;
      if (extra && it == 1) begin
        req_i = 1'b1; pl_i = pl + 2'd1; tr_base_i = base + 32'h100;
      end
      if (mem_req_o) begin
        if (wcnt >= dly) begin
          if (nrd < 2) begin r_addr[nrd] = mem_addr_o; r_wide[nrd] = mem_wide_o; end
          nrd++;
          mem_ack_i = 1'b1; mem_rdata_i = mem_val(mem_addr_o);
          wcnt = 0; dly = $urandom_range(0, 3);
        end else begin
          mem_ack_i = 1'b0; wcnt++;
        end
      end else mem_ack_i = 1'b0;
      if (done_o) begin
        ndone++;
        g_sp = sp_o; g_ss = ss_o; g_err = err_code_o; g_fault = fault_o; g_fatal = fatal_o;
        after = 3;
      end else if (after > 0) after--;
    end
    mem_ack_i = 1'b0;
    chk(ndone == 1, "R8 done count", ndone, 1);
    if (bad) begin
      chk(g_fatal == 1 && g_fault == 0, "R7 fatal flags", {g_fatal, g_fault}, 2'b10);
      chk(nrd == 0, "R7 no read", nrd, 0);
    end else if (flt) begin
      chk(g_fault == 1 && g_fatal == 0, is32 ? "R4 fault flags" : "R5 fault flags", {g_fault, g_fatal}, 2'b10);
      chk(g_err == (sel & 16'hFFFC), "R6 error code", g_err, sel & 16'hFFFC);
      chk(nrd == 0, "R6 no read", nrd, 0);
    end else begin
      chk(g_fault == 0 && g_fatal == 0 && g_err == 0, "R10 clean flags", {g_fault, g_fatal, g_err}, 0);
      chk(nrd == 2, is32 ? "R4 read count" : "R5 read count", nrd, 2);
      chk(r_addr[0] == a_sp && r_wide[0] == is32, is32 ? "R2 sp read" : "R3 sp read", r_addr[0], a_sp);
      chk(r_addr[1] == a_ss && r_wide[1] == 0, is32 ? "R2 ss read" : "R3 ss read", r_addr[1], a_ss);
      chk(g_sp == e_sp, is32 ? "R2 sp value" : "R3 sp value", g_sp, e_sp);
      chk(g_ss == mem_val(a_ss)[15:0], is32 ? "R2 ss value" : "R3 ss value", g_ss, mem_val(a_ss)[15:0]);
    end
  endtask

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!done_o && !mem_req_o && !fault_o && !fatal_o, "R1 reset outputs",
        {done_o, mem_req_o, fault_o, fatal_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!done_o && !mem_req_o, "R1 idle after reset", {done_o, mem_req_o}, 0);
    for (int l = 0; l < 3; l++) run(2'(l), 16'h0030, 32'h0001_0000, 32'h67, 4'd9, 1, 0);  // R2
    run(2'd1, 16'h0033, 32'h0002_0040, 32'h67, 4'd11, 1, 0);                               // R2
    for (int l = 0; l < 3; l++) run(2'(l), 16'h0028, 32'h0000_8000, 32'h2B, 4'd1, 1, 0);  // R3
    run(2'd2, 16'h002B, 32'h0000_9F00, 32'h2B, 4'd3, 1, 0);                                // R3
    run(2'd2, 16'h1237, 32'h0003_0000, 32'd27, 4'd9, 1, 0);  // R4 boundary pass
    run(2'd2, 16'h1237, 32'h0003_0000, 32'd26, 4'd9, 1, 0);  // R4 boundary fault, R6
    run(2'd2, 16'hFFFF, 32'h0003_0000, 32'd13, 4'd1, 1, 0);  // R5 boundary pass
    run(2'd2, 16'hFFFF, 32'h0003_0000, 32'd12, 4'd1, 1, 0);  // R5 boundary fault, R6
    run(2'd0, 16'h0008, 32'h0004_0000, 32'h67, 4'd9, 0, 0);  // R7 invalid
    run(2'd0, 16'h0008, 32'h0004_0000, 32'h67, 4'd2, 1, 0);  // R7 bad type
    run(2'd1, 16'h0008, 32'h0004_0000, 32'h67, 4'd0, 1, 0);  // R7 bad type
    run(2'd0, 16'h0010, 32'h0005_0000, 32'h67, 4'd9, 1, 1);  // R8 busy ignore
    run(2'd0, 16'h0010, 32'h0005_0000, 32'h2B, 4'd1, 1, 1);  // R8 busy ignore
    for (int k = 0; k < 60; k++) begin
      logic [3:0] t;
      int sel_t = $urandom_range(0, 4);
      t = (sel_t == 0) ? 4'd1 : (sel_t == 1) ? 4'd3 : (sel_t == 2) ? 4'd9 :
          (sel_t == 3) ? 4'd11 : 4'($urandom);
      run(2'($urandom_range(0, 2)), 16'($urandom), $urandom, 32'($urandom_range(0, 40)),
          t, $urandom_range(0, 9) != 0, $urandom_range(0, 4) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule